// File: doc/BRIEF.md
# DMA Bandwidth Throttle Scheduler

This block sets the pace at which a DMA engine asks for bus time. A transfer is started with a total byte count and a choice of one of two bus profiles. The block then requests the transfer one block at a time. After each block completes, it stays quiet for a programmed number of microsecond ticks before it asks for the next block. This continues until the whole count has been requested. Each of the two bus profiles has its own block size and its own back-off gap. Large blocks with short gaps give throughput. Small blocks with long gaps leave bandwidth for other bus masters.

The engine that moves the data watches `blk_req` and `blk_len`. It pulses `blk_done` when the current block has been served. A free-running one-microsecond strobe on `us_tick` times the gaps. `xfer_done` pulses once when the last block has completed. `abort` drops any activity at once.

Top module: `dma_throttle_sched`

## Requirements
- R1: While `rst_n` is low and after its release, `blk_req` and `xfer_done` are 0 and `blk_len` is 0.
- R2: From idle, a `start` pulse with a nonzero `total_bytes` makes `blk_req` high in the next cycle. At that moment the profile picked by `bus_sel` (0 selects the `_a` inputs, 1 selects the `_b` inputs) is captured, along with the total count. Later changes to the configuration inputs have no effect on that transfer.
- R3: The block size is 32 shifted left by the 3-bit size code, so code 0 gives 32 bytes and code 7 gives 4096. `blk_len` shows this size for every block except a short final one.
- R4: When fewer bytes remain than the block size, `blk_len` shows the remaining count. While `blk_req` is high and no `blk_done` has been seen, `blk_len` stays stable.
- R5: A `blk_done` that is not for the final block, with an effective gap G > 0, makes `blk_req` low. Counting starts in the cycle after `blk_done`. `blk_req` rises again in the cycle after the G-th `us_tick` and not earlier.
- R6: With a gap of 0, `blk_req` stays high in the cycle after `blk_done` and shows the next block's length.
- R7: A back-off setting above 64 counts as 64 ticks.
- R8: After `blk_done` for the final block, no gap is inserted. `xfer_done` is high for exactly one cycle, in the cycle after `blk_done`, and `blk_req` stays low.
- R9: A `start` with `total_bytes` of 0 gives a single `xfer_done` pulse in the next cycle and no request.
- R10: `abort` returns the block to idle at the next edge from any state. The next cycle has `blk_req` and `xfer_done` low, and no request follows until a new `start`.
- R11: A `start` while a transfer is in progress is ignored. A `blk_done` while `blk_req` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| abort | input | 1 | Cancel all activity, return to idle |
| total_bytes | input | CNT_W | Total bytes of the transfer |
| bus_sel | input | 1 | Profile select: 0 = profile a, 1 = profile b |
| size_code_a | input | CODE_W | Block size code for profile a |
| backoff_a | input | GAP_W | Gap in microsecond ticks for profile a |
| size_code_b | input | CODE_W | Block size code for profile b |
| backoff_b | input | GAP_W | Gap in microsecond ticks for profile b |
| blk_done | input | 1 | Current block has been served |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| blk_req | output | 1 | Block request, held until `blk_done` |
| blk_len | output | LEN_W | Byte length of the requested block |
| xfer_done | output | 1 | One-cycle pulse after the final block |

## Verification
Some rules are checked by the assertions on every cycle. A request never rises without a preceding `start` or tick. The length stays in range and stable while a request is pending. The finished pulse is one cycle wide, never coincides with a request, and follows only `blk_done` or `start`. An abort clears both outputs. Other behaviour depends on captured configuration and running byte counts, so only the bench scenarios show it: exact block lengths, the cut-down final block, tick-exact gap lengths, the clamp at 64, and the fact that changes to inputs after `start` are ignored.

// File: rtl/dma_throttle_sched.sv
module dma_throttle_sched #(
  parameter int CNT_W     = 24,
  parameter int CODE_W    = 3,
  parameter int MIN_SHIFT = 5,
  parameter int GAP_W     = 7,
  parameter int GAP_MAX   = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 abort,
  input  logic [CNT_W-1:0]     total_bytes,
  input  logic                 bus_sel,
  input  logic [CODE_W-1:0]    size_code_a,
  input  logic [GAP_W-1:0]     backoff_a,
  input  logic [CODE_W-1:0]    size_code_b,
  input  logic [GAP_W-1:0]     backoff_b,
  input  logic                 blk_done,
  input  logic                 us_tick,
  output logic                 blk_req,
  output logic [MIN_SHIFT+(1<<CODE_W)-1:0] blk_len,
  output logic                 xfer_done
);
  localparam int LEN_W = MIN_SHIFT + (1 << CODE_W);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_GAP} st_t;

  st_t                st;
  logic [CNT_W-1:0]   rem;
  logic [CODE_W-1:0]  code_q;
  logic [GAP_W-1:0]   gap_q, gap_cnt;
  logic [GAP_W-1:0]   gap_raw, gap_sel;
  logic [LEN_W-1:0]   blk_size;
  logic               last_blk;

  assign gap_raw  = bus_sel ? backoff_b : backoff_a;
  assign gap_sel  = (gap_raw > GAP_W'(GAP_MAX)) ? GAP_W'(GAP_MAX) : gap_raw;
  assign blk_size = LEN_W'(1) << (int'(code_q) + MIN_SHIFT);
  assign last_blk = rem <= CNT_W'(blk_size);
  assign blk_req  = (st == S_REQ);
  assign blk_len  = !blk_req ? '0 : (last_blk ? rem[LEN_W-1:0] : blk_size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rem       <= '0;
      code_q    <= '0;
      gap_q     <= '0;
      gap_cnt   <= '0;
      xfer_done <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      if (abort) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            rem    <= total_bytes;
            code_q <= bus_sel ? size_code_b : size_code_a;
            gap_q  <= gap_sel;
            if (total_bytes == '0) xfer_done <= 1'b1;
            else                   st        <= S_REQ;
          end
          S_REQ: if (blk_done) begin
            rem <= rem - CNT_W'(blk_len);
            if (last_blk) begin
              st        <= S_IDLE;
              xfer_done <= 1'b1;
            end else if (gap_q != '0) begin
              st      <= S_GAP;
              gap_cnt <= gap_q;
            end
          end
          S_GAP: if (us_tick) begin
            gap_cnt <= gap_cnt - 1'b1;
            if (gap_cnt == GAP_W'(1)) st <= S_REQ;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_throttle_sched_chk.sv
module dma_throttle_sched_chk #(
  parameter int LEN_W   = 13,
  parameter int LEN_MAX = 4096
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             abort,
  input logic             blk_done,
  input logic             us_tick,
  input logic             blk_req,
  input logic [LEN_W-1:0] blk_len,
  input logic             xfer_done
);
  a_r3_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    blk_req |-> (blk_len != '0 && blk_len <= LEN_W'(LEN_MAX)));

  a_r4_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_req && !blk_done && !abort) |=> (blk_req && $stable(blk_len)));

  a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_req) |-> ($past(start) || $past(us_tick)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  a_r8_done_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !blk_req);

  a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> ($past(blk_done) || $past(start)));

  a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!blk_req && !xfer_done));
endmodule

bind dma_throttle_sched dma_throttle_sched_chk #(
  .LEN_W  (MIN_SHIFT + (1 << CODE_W)),
  .LEN_MAX(1 << (MIN_SHIFT + (1 << CODE_W) - 1))
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .abort    (abort),
  .blk_done (blk_done),
  .us_tick  (us_tick),
  .blk_req  (blk_req),
  .blk_len  (blk_len),
  .xfer_done(xfer_done)
);

// File: tb/tb_dma_throttle_sched.sv
module tb_dma_throttle_sched;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, abort = 1'b0, bus_sel = 1'b0;
  logic [23:0] total_bytes = '0;
  logic [2:0]  size_code_a = '0, size_code_b = '0;
  logic [6:0]  backoff_a = '0, backoff_b = '0;
  logic        blk_done = 1'b0, us_tick = 1'b0;
  logic        blk_req, xfer_done;
  logic [12:0] blk_len;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_throttle_sched dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .total_bytes(total_bytes), .bus_sel(bus_sel),
    .size_code_a(size_code_a), .backoff_a(backoff_a),
    .size_code_b(size_code_b), .backoff_b(backoff_b),
    .blk_done(blk_done), .us_tick(us_tick),
    .blk_req(blk_req), .blk_len(blk_len), .xfer_done(xfer_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_gap(input int g);
    return (g > 64) ? 64 : g;
  endfunction

  function automatic int exp_len(input int rem, input int code);
    int sz = 32 << code;
    return (rem < sz) ? rem : sz;
  endfunction

  task automatic scramble_cfg();
    size_code_a = 3'($urandom % 8);
    size_code_b = 3'($urandom % 8);
    backoff_a   = 7'($urandom % 128);
    backoff_b   = 7'($urandom % 128);
    bus_sel     = 1'($urandom % 2);
    total_bytes = 24'($urandom % 9000);
  endtask

  task automatic run_xfer(input int total, input bit sel, input int ca, input int ga,
                          input int cb, input int gb, input bit inj);
    int code = sel ? cb : ca;
    int g    = eff_gap(sel ? gb : ga);
    int rem  = total;
    int len;
    size_code_a = 3'(ca); backoff_a = 7'(ga);
    size_code_b = 3'(cb); backoff_b = 7'(gb);
    bus_sel = sel; total_bytes = 24'(total); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    scramble_cfg();
    if (total == 0) begin
      chk(xfer_done == 1'b1, "R9 done", int'(xfer_done), 1);
      chk(blk_req == 1'b0, "R9 no req", int'(blk_req), 0);
      @(negedge clk);
      chk(xfer_done == 1'b0, "R9 single", int'(xfer_done), 0);
      return;
    end
    while (rem > 0) begin
      len = exp_len(rem, code);
      chk(blk_req == 1'b1, "R2/R5/R6 req", int'(blk_req), 1);
      chk(int'(blk_len) == len, (len == (32 << code)) ? "R3 len" : "R4 len",
          int'(blk_len), len);
      for (int i = 0; i < (inj ? 2 : int'($urandom % 4)); i++) begin
        if (inj && i == 0) begin start = 1'b1; total_bytes = 24'(5000); end
        us_tick = 1'($urandom % 2);
        @(negedge clk);
        start = 1'b0; us_tick = 1'b0;
        chk(blk_req == 1'b1, inj ? "R11 busy start" : "R4 held", int'(blk_req), 1);
        chk(int'(blk_len) == len, "R4 stable", int'(blk_len), len);
      end
      inj = 1'b0;
      blk_done = 1'b1;
      @(negedge clk);
      blk_done = 1'b0;
      rem -= len;
      if (rem == 0) begin
        chk(xfer_done == 1'b1, "R8 done", int'(xfer_done), 1);
        chk(blk_req == 1'b0, "R8 no req", int'(blk_req), 0);
        @(negedge clk);
        chk(xfer_done == 1'b0, "R8 single", int'(xfer_done), 0);
        chk(blk_req == 1'b0, "R8 stays idle", int'(blk_req), 0);
      end else if (g != 0) begin
        chk(blk_req == 1'b0, "R5 gap low", int'(blk_req), 0);
        for (int t = 1; t <= g; t++) begin
          for (int k = 0; k < int'($urandom % 3); k++) begin
            blk_done = 1'($urandom % 2);
            @(negedge clk);
            blk_done = 1'b0;
            chk(blk_req == 1'b0, "R5/R11 gap idle", int'(blk_req), 0);
          end
          us_tick = 1'b1;
          @(negedge clk);
          us_tick = 1'b0;
          if (t < g) chk(blk_req == 1'b0, (t == 64) ? "R7 clamp" : "R5 early", int'(blk_req), 0);
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(blk_req == 1'b0 && xfer_done == 1'b0 && blk_len == '0, "R1 in reset",
        int'(blk_req) + int'(xfer_done) + int'(blk_len), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(blk_req == 1'b0 && xfer_done == 1'b0 && blk_len == '0, "R1 after reset",
        int'(blk_req) + int'(xfer_done) + int'(blk_len), 0);

    run_xfer(5000, 1'b0, 7, 1, 0, 9, 1'b0);     // R3 largest size, R4 tail
    run_xfer(128, 1'b1, 5, 5, 1, 2, 1'b0);      // R3 exact multiple
    run_xfer(200, 1'b0, 0, 0, 3, 3, 1'b0);      // R6 zero gap
    run_xfer(40, 1'b1, 2, 0, 0, 100, 1'b0);     // R7 gap above 64
    run_xfer(33, 1'b0, 0, 127, 4, 0, 1'b0);     // R7 max setting
    run_xfer(0, 1'b0, 1, 1, 1, 1, 1'b0);        // R9 zero count
    run_xfer(100, 1'b0, 0, 2, 6, 6, 1'b1);      // R11 start while busy

    // R10 abort during request
    size_code_a = 3'd1; backoff_a = 7'd3; bus_sel = 1'b0;
    total_bytes = 24'd1000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(blk_req == 1'b1, "R2 req", int'(blk_req), 1);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk(blk_req == 1'b0 && xfer_done == 1'b0, "R10 abort req", int'(blk_req), 0);
    for (int i = 0; i < 5; i++) begin
      us_tick = 1'b1; @(negedge clk); us_tick = 1'b0;
      chk(blk_req == 1'b0, "R10 stays idle", int'(blk_req), 0);
    end

    // R10 abort during gap
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    blk_done = 1'b1;
    @(negedge clk); blk_done = 1'b0;
    chk(blk_req == 1'b0, "R5 gap low", int'(blk_req), 0);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    for (int i = 0; i < 6; i++) begin
      us_tick = 1'b1; @(negedge clk); us_tick = 1'b0;
      chk(blk_req == 1'b0 && xfer_done == 1'b0, "R10 gap abort", int'(blk_req), 0);
    end

    // R11 completion while idle ignored
    blk_done = 1'b1;
    @(negedge clk); blk_done = 1'b0;
    chk(xfer_done == 1'b0 && blk_req == 1'b0, "R11 idle done", int'(xfer_done), 0);

    for (int n = 0; n < 30; n++) begin
      int ca = int'($urandom % 8), cb = int'($urandom % 8);
      bit sel = 1'($urandom % 2);
      int sz = 32 << (sel ? cb : ca);
      run_xfer(1 + int'($urandom % (3 * sz)), sel, ca, int'($urandom % 71),
               cb, int'($urandom % 71), 1'($urandom % 4 == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule